// File: doc/BRIEF.md
# I2C Bus Idle Watchdog with Stuck-Bus Recovery

The block sits beside an I2C controller and watches the two bus lines. An idle timer restarts on every transition of SCL or SDA. When the bus has been quiet for the whole timeout, the block checks the SDA level. If SDA is high, nothing is holding the bus, so the block emits a one-cycle "bus free" pulse and drops its busy flag. If SDA is low, a target device is assumed to be stuck partway through a byte. The block then drives a fixed train of clock pulses on SCL, through an open-drain pull-low enable, so that the target can shift out the rest of the byte and let go of SDA.

Two idle timeouts are available. The long one is nominally one second and the short one is nominally fifty microseconds. Both are given in system-clock cycles through parameters derived from a clock-frequency parameter. A busy flag follows START and STOP conditions on the bus. A disable input stops the watchdog. The block never drives SDA and does not decode addresses or data.

Top module: `i2c_hang_watchdog`

## Requirements
- R1: After reset, `bus_busy_o`, `bus_free_o`, `recovery_active_o` and `scl_pull_low_o` are all low.
- R2: With `wd_fast_i` low and SDA high, `bus_free_o` is high for exactly one cycle, on the clock edge that is SLOW_CYC+3 edges after the last change of either line. The 3 cycles are two synchronizer stages and one edge-detect stage.
- R3: If `wd_fast_i` is high when the timer restarts, the free pulse comes FAST_CYC+3 edges after the last line change.
- R4: A falling edge on SDA while SCL is high sets `bus_busy_o`, and a rising edge on SDA while SCL is high clears it, each 3 edges after the line change. A free declaration also clears `bus_busy_o`.
- R5: A change on either line restarts the idle timer. A second change up to and including the timeout length after a first change suppresses the first expiry. The pulse then follows timeout+3 edges after the second change.
- R6: If SDA is low at expiry, recovery starts instead of a free pulse. `recovery_active_o` rises at the same edge a free pulse would, and `scl_pull_low_o` makes exactly RECOVERY_PULSES (default 9) low phases. Each low phase lasts PULSE_LOW_CYC cycles and each high phase lasts PULSE_HIGH_CYC cycles. No free pulse is given during recovery.
- R7: Edges caused by the block's own SCL pulses do not restart the timer. When the pulse train ends, the timer restarts. If SDA is still low, the next recovery begins exactly SLOW_CYC cycles after `recovery_active_o` falls.
- R8: If SDA is released during recovery, the pulse train still completes. The free pulse then appears SLOW_CYC cycles after `recovery_active_o` falls.
- R9: While `wd_disable_i` is high, `bus_free_o` and `scl_pull_low_o` stay low, whatever the bus does.
- R10: Raising `wd_disable_i` during recovery clears `recovery_active_o` and `scl_pull_low_o` on the next clock edge.
- R11: A change of `wd_fast_i` while the timer is running does not change the current countdown. It takes effect at the next restart.
- R12: After a free pulse, no further free pulse occurs until the bus shows new activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level (asynchronous) |
| sda_i | input | 1 | Sensed SDA line level (asynchronous) |
| wd_disable_i | input | 1 | Turns the watchdog off; aborts any recovery |
| wd_fast_i | input | 1 | Selects the short idle timeout at the next timer restart |
| bus_busy_o | output | 1 | High between a START and a STOP or a free declaration |
| bus_free_o | output | 1 | One-cycle pulse: idle timeout expired with SDA high |
| recovery_active_o | output | 1 | High while the recovery pulse train runs |
| scl_pull_low_o | output | 1 | Open-drain enable: pulls SCL low when high |

## Verification
A timer that counts wrong, or that restarts on the wrong event, shows up as a free pulse or a recovery start on a different cycle from timeout+3. A sweep of the gap between two line changes exposes an off-by-one at the restart/expiry boundary within one timeout length. A wrong recovery sequencer count or state shows up within one pulse train, as a wrong number of low phases or a wrong phase width on the pull-low output. A broken re-arm or a broken abort path shows up as a wrong gap length before the next recovery, or as a pull-low output that stays high one cycle after disable.

// File: rtl/i2c_wd_pkg.sv
package i2c_wd_pkg;

    // Recovery sequencer phases
    typedef enum logic [1:0] {
        RC_IDLE = 2'd0,
        RC_LOW  = 2'd1,
        RC_HIGH = 2'd2
    } rc_state_e;

    // Line indices inside the synchronized bus vector
    localparam int unsigned LINE_SDA = 0;
    localparam int unsigned LINE_SCL = 1;
    localparam int unsigned N_LINES  = 2;

endpackage

// File: rtl/i2c_wd_sync.sv
module i2c_wd_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_wd_timer.sv
module i2c_wd_timer #(
    parameter int unsigned SLOW_CYC = 1000,
    parameter int unsigned FAST_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic fast_i,
    input  logic disable_i,
    output logic expire_o
);

    localparam int unsigned MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int unsigned TW      = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] SLOW_LAST = TW'(SLOW_CYC - 1);
    localparam logic [TW-1:0] FAST_LAST = TW'(FAST_CYC - 1);

    typedef struct packed {
        logic          run;
        logic          dis;
        logic [TW-1:0] cnt;
        logic [TW-1:0] last;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic hit;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.dis = disable_i;
        hit       = tmr_q.run && (tmr_q.cnt == tmr_q.last);
        expire_o  = hit && !disable_i && !restart_i;

        if (disable_i) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (restart_i || tmr_q.dis) begin
            // timeout selection is latched only here
            tmr_d.run  = 1'b1;
            tmr_d.cnt  = '0;
            tmr_d.last = fast_i ? FAST_LAST : SLOW_LAST;
        end else if (hit) begin
            tmr_d.run = 1'b0;
        end else if (tmr_q.run) begin
            tmr_d.cnt = tmr_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.run  <= 1'b0;
            tmr_q.dis  <= 1'b1;
            tmr_q.cnt  <= '0;
            tmr_q.last <= SLOW_LAST;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R2: the count never passes the latched limit
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.run |-> (tmr_q.cnt <= tmr_q.last));

    // R12: an expiry stops the timer until the next restart
    p_stop_after_expire_r12: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !tmr_q.run);

    // R11: a running countdown keeps its limit
    p_limit_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.run && !restart_i && !tmr_q.dis) |=> $stable(tmr_q.last));

endmodule

// File: rtl/i2c_wd_recovery.sv
module i2c_wd_recovery
    import i2c_wd_pkg::*;
#(
    parameter int unsigned LOW_CYC  = 250,
    parameter int unsigned HIGH_CYC = 250,
    parameter int unsigned PULSES   = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    output logic pull_o,
    output logic active_o,
    output logic rearm_o
);

    localparam int unsigned MAX_PH = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int unsigned PW     = $clog2(MAX_PH + 1);
    localparam int unsigned IW     = $clog2(PULSES + 1);
    localparam logic [PW-1:0] LOW_LAST  = PW'(LOW_CYC - 1);
    localparam logic [PW-1:0] HIGH_LAST = PW'(HIGH_CYC - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(PULSES - 1);

    typedef struct packed {
        rc_state_e     state;
        logic [PW-1:0] ph;
        logic [IW-1:0] idx;
    } rc_t;

    rc_t rc_d, rc_q;

    always_comb begin
        rc_d    = rc_q;
        rearm_o = 1'b0;
        unique case (rc_q.state)
            RC_IDLE: begin
                if (start_i) begin
                    rc_d.state = RC_LOW;
                    rc_d.ph    = '0;
                    rc_d.idx   = '0;
                end
            end
            RC_LOW: begin
                if (rc_q.ph == LOW_LAST) begin
                    rc_d.state = RC_HIGH;
                    rc_d.ph    = '0;
                end else begin
                    rc_d.ph = rc_q.ph + PW'(1);
                end
            end
            RC_HIGH: begin
                if (rc_q.ph == HIGH_LAST) begin
                    rc_d.ph = '0;
                    if (rc_q.idx == IDX_LAST) begin
                        rc_d.state = RC_IDLE;
                        rearm_o    = 1'b1;
                    end else begin
                        rc_d.state = RC_LOW;
                        rc_d.idx   = rc_q.idx + IW'(1);
                    end
                end else begin
                    rc_d.ph = rc_q.ph + PW'(1);
                end
            end
            default: rc_d.state = RC_IDLE;
        endcase

        if (abort_i) begin
            rc_d.state = RC_IDLE;
            rc_d.ph    = '0;
            rc_d.idx   = '0;
            rearm_o    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_q.state <= RC_IDLE;
            rc_q.ph    <= '0;
            rc_q.idx   <= '0;
        end else begin
            rc_q <= rc_d;
        end
    end

    assign pull_o   = (rc_q.state == RC_LOW);
    assign active_o = (rc_q.state != RC_IDLE);

    // R6: pulse index stays inside the train
    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rc_q.idx < IW'(PULSES));

    // R6: a train that ends by itself ends after its last pulse
    p_full_train_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active_o) && !$past(abort_i)) |-> ($past(rc_q.idx) == IDX_LAST));

    // R10: abort releases SCL on the next edge
    p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!active_o && !pull_o));

endmodule

// File: rtl/i2c_hang_watchdog.sv
module i2c_hang_watchdog
    import i2c_wd_pkg::*;
#(
    parameter int unsigned CLK_HZ          = 50_000_000,
    parameter int unsigned SLOW_CYC        = CLK_HZ,
    parameter int unsigned FAST_CYC        = CLK_HZ / 20_000,
    parameter int unsigned PULSE_LOW_CYC   = CLK_HZ / 200_000,
    parameter int unsigned PULSE_HIGH_CYC  = CLK_HZ / 200_000,
    parameter int unsigned RECOVERY_PULSES = 9,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wd_disable_i,
    input  logic wd_fast_i,
    output logic bus_busy_o,
    output logic bus_free_o,
    output logic recovery_active_o,
    output logic scl_pull_low_o
);

    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic busy;
        logic free;
    } mon_t;

    mon_t mon_d, mon_q;

    logic [N_LINES-1:0] lines_async;
    logic [N_LINES-1:0] lines_s;
    logic scl_s, sda_s;
    logic activity, restart, expire;
    logic start_cond, stop_cond, rec_start;
    logic rec_active, rec_pull, rec_rearm;

    assign lines_async[LINE_SCL] = scl_i;
    assign lines_async[LINE_SDA] = sda_i;

    i2c_wd_sync #(
        .WIDTH   (N_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lines_async),
        .sync_o  (lines_s)
    );

    assign scl_s = lines_s[LINE_SCL];
    assign sda_s = lines_s[LINE_SDA];

    i2c_wd_timer #(
        .SLOW_CYC (SLOW_CYC),
        .FAST_CYC (FAST_CYC)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .fast_i    (wd_fast_i),
        .disable_i (wd_disable_i),
        .expire_o  (expire)
    );

    i2c_wd_recovery #(
        .LOW_CYC  (PULSE_LOW_CYC),
        .HIGH_CYC (PULSE_HIGH_CYC),
        .PULSES   (RECOVERY_PULSES)
    ) recovery_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (rec_start),
        .abort_i  (wd_disable_i),
        .pull_o   (rec_pull),
        .active_o (rec_active),
        .rearm_o  (rec_rearm)
    );

    always_comb begin
        mon_d       = mon_q;
        mon_d.scl_p = scl_s;
        mon_d.sda_p = sda_s;

        activity   = (scl_s != mon_q.scl_p) || (sda_s != mon_q.sda_p);
        // own recovery edges are not bus activity
        restart    = (activity && !rec_active) || rec_rearm;
        start_cond = scl_s && mon_q.scl_p && mon_q.sda_p && !sda_s;
        stop_cond  = scl_s && mon_q.scl_p && !mon_q.sda_p && sda_s;
        rec_start  = expire && !sda_s;

        if (start_cond) begin
            mon_d.busy = 1'b1;
        end else if (stop_cond) begin
            mon_d.busy = 1'b0;
        end
        mon_d.free = expire && sda_s;
        if (mon_d.free) begin
            mon_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q.scl_p <= 1'b1;
            mon_q.sda_p <= 1'b1;
            mon_q.busy  <= 1'b0;
            mon_q.free  <= 1'b0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign bus_busy_o        = mon_q.busy;
    assign bus_free_o        = mon_q.free;
    assign recovery_active_o = rec_active;
    assign scl_pull_low_o    = rec_pull;

    // R12: the free indication lasts one cycle
    p_free_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free_o |=> !bus_free_o);

    // R9: a disabled watchdog neither frees nor drives SCL
    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_disable_i |=> (!bus_free_o && !scl_pull_low_o));

    // R6: no free declaration while a recovery train is running
    p_free_excl_rec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_free_o && recovery_active_o));

    // R4: a free declaration leaves the bus idle
    p_free_clears_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free_o |-> !bus_busy_o);

endmodule

// File: tb/i2c_hang_watchdog_tb_top.sv
module i2c_hang_watchdog_tb_top;

    localparam int T_SLOW = 40;
    localparam int T_FAST = 12;
    localparam int P_LOW  = 5;
    localparam int P_HIGH = 4;
    localparam int N_PUL  = 9;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic wd_disable = 1'b0;
    logic wd_fast = 1'b0;
    logic busy, free, rec, pull;
    logic scl_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    assign scl_line = scl_drv & ~pull;

    i2c_hang_watchdog #(
        .CLK_HZ          (1_000_000),
        .SLOW_CYC        (T_SLOW),
        .FAST_CYC        (T_FAST),
        .PULSE_LOW_CYC   (P_LOW),
        .PULSE_HIGH_CYC  (P_HIGH),
        .RECOVERY_PULSES (N_PUL),
        .SYNC_STAGES     (2)
    ) dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .scl_i             (scl_line),
        .sda_i             (sda_drv),
        .wd_disable_i      (wd_disable),
        .wd_fast_i         (wd_fast),
        .bus_busy_o        (busy),
        .bus_free_o        (free),
        .recovery_active_o (rec),
        .scl_pull_low_o    (pull)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // edges elapsed from the current negedge until free is seen high
    task automatic edges_to_free(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!free && n < 5000);
    endtask

    task automatic edges_to_rec(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rec && n < 5000);
    endtask

    // profile a recovery train; entered on a sample where rec is high
    task automatic rec_profile(input int rel_at, output int lows, output int bad, output int frees);
        int lowrun = 0;
        int highrun = 0;
        int idx = 0;
        lows = 0; bad = 0; frees = 0;
        while (rec && idx < 2000) begin
            if (free) frees++;
            if (pull) begin
                if (highrun != 0 && highrun != P_HIGH) bad++;
                highrun = 0;
                lowrun++;
            end else begin
                if (lowrun != 0) begin
                    lows++;
                    if (lowrun != P_LOW) bad++;
                    lowrun = 0;
                end
                highrun++;
            end
            idx++;
            if (idx == rel_at) sda_drv = 1'b1;
            @(negedge clk);
        end
        if (highrun != P_HIGH) bad++;
    endtask

    // samples (this one included) before cond-signal goes high
    task automatic gap_until(input bit use_rec, output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if ((use_rec ? rec : free) || n > 5000) break;
            n++;
        end
    endtask

    initial begin
        int n, lows, bad, frees, seen;

        step(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !free && !rec && !pull, "R1", {busy, free, rec, pull}, 0);

        // R2: slow timeout, two distinct SCL patterns
        scl_drv = 1'b0;
        edges_to_free(n);
        chk(n == T_SLOW + LAT, "R2 scl fall", n, T_SLOW + LAT);
        @(negedge clk);
        chk(!free, "R2 pulse width", free, 0);
        scl_drv = 1'b1;
        edges_to_free(n);
        chk(n == T_SLOW + LAT, "R2 scl rise", n, T_SLOW + LAT);

        // R12: no repeat pulse without activity
        seen = 0;
        repeat (3 * T_SLOW) begin
            @(negedge clk);
            if (free) seen++;
        end
        chk(seen == 0, "R12", seen, 0);

        // R3: fast timeout
        wd_fast = 1'b1;
        scl_drv = 1'b0;
        edges_to_free(n);
        chk(n == T_FAST + LAT, "R3", n, T_FAST + LAT);

        // R5: sweep of gap between two line changes
        for (int g = 1; g <= T_FAST; g++) begin
            scl_drv = ~scl_drv;
            seen = 0;
            repeat (g) begin
                @(negedge clk);
                if (free) seen++;
            end
            scl_drv = ~scl_drv;
            edges_to_free(n);
            chk(seen == 0 && n == T_FAST + LAT, "R5 gap sweep", n + 1000 * seen, T_FAST + LAT);
        end
        scl_drv = 1'b1;
        step(T_FAST + 8);

        // R11: speed-up change mid-count is deferred
        wd_fast = 1'b0;
        scl_drv = 1'b0;
        step(5);
        wd_fast = 1'b1;
        edges_to_free(n);
        chk(n + 5 == T_SLOW + LAT, "R11 deferred", n + 5, T_SLOW + LAT);
        scl_drv = 1'b1;
        edges_to_free(n);
        chk(n == T_FAST + LAT, "R11 applied", n, T_FAST + LAT);
        wd_fast = 1'b0;

        // R4: START, STOP, and free clearing busy
        sda_drv = 1'b0;
        step(LAT + 1);
        chk(busy, "R4 start", busy, 1);
        sda_drv = 1'b1;
        step(LAT + 1);
        chk(!busy, "R4 stop", busy, 0);
        sda_drv = 1'b0;
        step(LAT + 1);
        chk(busy, "R4 start again", busy, 1);
        scl_drv = 1'b0;
        @(negedge clk);
        sda_drv = 1'b1;
        edges_to_free(n);
        chk(n == T_SLOW + LAT && !busy, "R4 free clears busy", n + 1000 * busy, T_SLOW + LAT);
        scl_drv = 1'b1;
        edges_to_free(n);

        // R6: stuck SDA triggers a full recovery train
        sda_drv = 1'b0;
        edges_to_rec(n);
        chk(n == T_SLOW + LAT, "R6 start", n, T_SLOW + LAT);
        rec_profile(0, lows, bad, frees);
        chk(lows == N_PUL, "R6 pulse count", lows, N_PUL);
        chk(bad == 0, "R6 phase widths", bad, 0);
        chk(frees == 0, "R6 no free", frees, 0);

        // R7: re-arm and repeat while SDA stays low
        gap_until(1'b1, n);
        chk(n == T_SLOW, "R7 repeat gap", n, T_SLOW);
        rec_profile(0, lows, bad, frees);
        chk(lows == N_PUL && bad == 0, "R7 second train", lows + 100 * bad, N_PUL);

        // R8: SDA released mid-train
        gap_until(1'b1, n);
        chk(n == T_SLOW, "R8 third train gap", n, T_SLOW);
        rec_profile(20, lows, bad, frees);
        chk(lows == N_PUL && bad == 0, "R8 train completes", lows + 100 * bad, N_PUL);
        gap_until(1'b0, n);
        chk(n == T_SLOW, "R8 free after train", n, T_SLOW);

        // R10: disable aborts recovery
        sda_drv = 1'b0;
        edges_to_rec(n);
        step(7);
        wd_disable = 1'b1;
        @(negedge clk);
        chk(!rec && !pull, "R10 abort", {rec, pull}, 0);

        // R9: disabled watchdog stays quiet
        seen = 0;
        repeat (3 * T_SLOW) begin
            @(negedge clk);
            if (free || pull) seen++;
        end
        chk(seen == 0, "R9 disabled", seen, 0);
        sda_drv = 1'b1;
        seen = 0;
        repeat (3 * T_SLOW) begin
            @(negedge clk);
            if (free || pull) seen++;
        end
        chk(seen == 0 && !busy, "R9 disabled sda high", seen + 1000 * busy, 0);
        wd_disable = 1'b0;
        step(4);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule